// File: doc/BRIEF.md
# Receive Throttle Trigger

This block decides when an Ethernet MAC must slow down its link partner because the receive buffer is filling up. It compares the receive FIFO fill level against a programmed threshold. It then acts according to the link's duplex mode. In half duplex it drives a jam output that holds carrier on the wire for a programmable time. In full duplex it raises a pause-frame request, which the MAC transmitter acknowledges once it has queued the frame.

Two qualification schemes are available. In promiscuous-trigger mode no address decode is made: in half duplex a valid preamble alone starts the jam, and in full duplex the request goes out as soon as the level is reached. With that mode off, a trigger needs the receiver's address-match strobe and the matching enable bits. The jam length comes from a 4-bit code that maps to a nonlinear set of microsecond values, and the 10 Mb/s set is longer than the 100 Mb/s set. The block converts each value to cycles of its own clock.

Top module: `rx_throttle`

## Requirements
- R1: After reset, `jam_o` and `pause_req_o` are low.
- R2: The level is reached when `rx_level >= rx_thresh`. No jam and no pause request is started while `rx_level < rx_thresh`.
- R3: While `any_frame` is 1, the bits of `mode_en` and the `addr_hit` strobe have no effect on triggering.
- R4: In half duplex (`full_dup`=0) with `any_frame`=1 and the level reached, a `pre_ok` pulse sampled at a clock edge starts `jam_o` in the following cycle. Without a `pre_ok` pulse no jam starts.
- R5: In full duplex with `any_frame`=1, `pause_req_o` rises the cycle after the level is first reached, with no strobe needed.
- R6: With `any_frame`=0, a trigger needs an `addr_hit` pulse. `mode_en` bit 2 is a common enable, bit 0 enables the half-duplex jam, and bit 1 enables the full-duplex pause. A trigger happens only if bit 2 and the bit for the current duplex are both 1.
- R7: At 100 Mb/s (`spd_100`=1) the jam lasts the time given by `dur_code`: 0→5 µs, 1→10 µs, 2→15 µs, 3→25 µs, 4→50 µs. Codes 5..15 give (code−3)×50 µs. The cycle count is µs×CLK_MHZ.
- R8: At 10 Mb/s (`spd_100`=0) each duration is 2.2 µs longer. In tenths of a microsecond the cycle count is tenths×CLK_MHZ/10 (for example 7.2 µs at 5 MHz is 36 cycles).
- R9: The duration code and speed are sampled when the jam starts. Later changes do not alter a running jam.
- R10: A trigger that arrives while a jam is running is dropped. After the jam ends there is at least one idle cycle before a new jam can start.
- R11: `pause_req_o` stays high until a `pause_ack` pulse and falls in the following cycle. Only one request is outstanding at a time. No new request is raised until the level has fallen below the threshold and been reached again.
- R12: When `full_dup` changes, `jam_o` and `pause_req_o` drop in that same cycle, and any running jam or pending request is discarded.
- R13: `jam_o` is only ever high in half duplex and `pause_req_o` only in full duplex.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_thresh | input | LVL_W | Fill level at which throttling is wanted |
| pre_ok | input | 1 | One-cycle strobe: a valid preamble was seen |
| addr_hit | input | 1 | One-cycle strobe: destination address matched |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| dur_code | input | 4 | Jam duration code |
| any_frame | input | 1 | Promiscuous-trigger mode, overrides `mode_en` |
| mode_en | input | 3 | [2] common enable, [1] full-duplex pause enable, [0] half-duplex jam enable |
| pause_ack | input | 1 | One-cycle strobe from the MAC: pause frame queued |
| jam_o | output | 1 | Backpressure (jam) active |
| pause_req_o | output | 1 | Pause-frame request |

## Verification
The bench builds the block with CLK_MHZ=5 and LVL_W=8. With those values every duration is a whole number of cycles, including the 2.2 µs offset, which becomes 11 cycles. The longest code at 10 Mb/s lasts 3011 cycles, so the table's extremes at both speeds can be measured run by run against lengths the bench works out from the microsecond values. The short clock conversion also brings within reach back-to-back triggers at the end of a jam and duplex flips in the middle of a jam.

// File: rtl/rx_throttle_pkg.sv
package rx_throttle_pkg;

  // longest duration in tenths of a microsecond (code 15 at 10 Mb/s)
  localparam int unsigned MAX_TENTHS = 6022;

  typedef struct packed {
    logic qual_en;  // common enable for address-qualified triggers
    logic fd_en;    // pause requests in full duplex
    logic hd_en;    // jam in half duplex
  } thr_mode_t;

  // jam time at 100 Mb/s, whole microseconds
  function automatic int unsigned thr_base_us(input logic [3:0] code);
    int unsigned us;
    case (code)
      4'd0:    us = 5;
      4'd1:    us = 10;
      4'd2:    us = 15;
      4'd3:    us = 25;
      4'd4:    us = 50;
      default: us = (int'(code) - 3) * 50;
    endcase
    return us;
  endfunction

  // jam time in tenths of a microsecond, slow link adds 2.2 us
  function automatic int unsigned thr_tenths(input logic [3:0] code,
                                             input logic spd100);
    return thr_base_us(code) * 10 + (spd100 ? 0 : 22);
  endfunction

  function automatic int unsigned thr_cycles(input logic [3:0] code,
                                             input logic spd100,
                                             input int unsigned clk_mhz);
    return (thr_tenths(code, spd100) * clk_mhz) / 10;
  endfunction

endpackage

// File: rtl/thr_trig_dec.sv
module thr_trig_dec
  import rx_throttle_pkg::*;
#(
  parameter int LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic             pre_ok,
  input  logic             addr_hit,
  input  logic             full_dup,
  input  logic             any_frame,
  input  logic [2:0]       mode_en,
  input  logic             bp_busy,
  input  logic             pause_pend,
  input  logic             pause_armed,
  output logic             level_hit,
  output logic             dup_chg,
  output logic             bp_start,
  output logic             pause_start
);

  thr_mode_t mode;
  logic      dup_q;
  logic      hd_qual;
  logic      fd_qual;

  assign mode = thr_mode_t'(mode_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dup_q <= 1'b0;
    else        dup_q <= full_dup;
  end

  assign level_hit = (rx_level >= rx_thresh);
  assign dup_chg   = full_dup ^ dup_q;

  // promiscuous mode overrides the enable bits and the address strobe
  always_comb begin
    if (any_frame) begin
      hd_qual = pre_ok;
      fd_qual = 1'b1;
    end else begin
      hd_qual = addr_hit & mode.hd_en & mode.qual_en;
      fd_qual = addr_hit & mode.fd_en & mode.qual_en;
    end
  end

  assign bp_start    = !full_dup && !dup_chg && level_hit && hd_qual && !bp_busy;
  assign pause_start = full_dup && !dup_chg && level_hit && fd_qual &&
                       !pause_pend && pause_armed;

endmodule

// File: rtl/thr_bp_timer.sv
module thr_bp_timer
  import rx_throttle_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 25,
  parameter int          CNT_W   = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bp_start,
  input  logic       cancel,
  input  logic [3:0] dur_code,
  input  logic       spd_100,
  output logic       busy
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cancel)       cnt <= '0;
    else if (bp_start)     cnt <= CNT_W'(thr_cycles(dur_code, spd_100, CLK_MHZ));
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/thr_pause_unit.sv
module thr_pause_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_start,
  input  logic pause_ack,
  input  logic cancel,
  input  logic level_hit,
  output logic pend,
  output logic armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pend <= 1'b0;
    else if (cancel)      pend <= 1'b0;
    else if (pause_start) pend <= 1'b1;
    else if (pause_ack)   pend <= 1'b0;
  end

  // one request per threshold crossing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           armed <= 1'b1;
    else if (pause_start) armed <= 1'b0;
    else if (!level_hit)  armed <= 1'b1;
  end

endmodule

// File: rtl/rx_throttle.sv
module rx_throttle
  import rx_throttle_pkg::*;
#(
  parameter int          LVL_W   = 12,
  parameter int unsigned CLK_MHZ = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic             pre_ok,
  input  logic             addr_hit,
  input  logic             full_dup,
  input  logic             spd_100,
  input  logic [3:0]       dur_code,
  input  logic             any_frame,
  input  logic [2:0]       mode_en,
  input  logic             pause_ack,
  output logic             jam_o,
  output logic             pause_req_o
);

  localparam int CNT_W = $clog2(MAX_TENTHS * CLK_MHZ / 10 + 1);

  // named internal events, visible to the bound checker
  logic level_hit_w;
  logic dup_chg_w;
  logic bp_start_w;
  logic pause_start_w;
  logic bp_busy_w;
  logic pend_w;
  logic armed_w;

  thr_trig_dec #(.LVL_W(LVL_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_level    (rx_level),
    .rx_thresh   (rx_thresh),
    .pre_ok      (pre_ok),
    .addr_hit    (addr_hit),
    .full_dup    (full_dup),
    .any_frame   (any_frame),
    .mode_en     (mode_en),
    .bp_busy     (bp_busy_w),
    .pause_pend  (pend_w),
    .pause_armed (armed_w),
    .level_hit   (level_hit_w),
    .dup_chg     (dup_chg_w),
    .bp_start    (bp_start_w),
    .pause_start (pause_start_w)
  );

  thr_bp_timer #(.CLK_MHZ(CLK_MHZ), .CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bp_start (bp_start_w),
    .cancel   (dup_chg_w),
    .dur_code (dur_code),
    .spd_100  (spd_100),
    .busy     (bp_busy_w)
  );

  thr_pause_unit u_pause (
    .clk         (clk),
    .rst_n       (rst_n),
    .pause_start (pause_start_w),
    .pause_ack   (pause_ack),
    .cancel      (dup_chg_w),
    .level_hit   (level_hit_w),
    .pend        (pend_w),
    .armed       (armed_w)
  );

  // the current duplex masks the outputs so a flip silences them at once
  assign jam_o       = bp_busy_w & ~full_dup;
  assign pause_req_o = pend_w & full_dup;

endmodule

// File: rtl/rx_throttle_chk.sv
module rx_throttle_chk #(
  parameter int LVL_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] rx_thresh,
  input logic             full_dup,
  input logic             pause_ack,
  input logic             jam_o,
  input logic             pause_req_o,
  input logic             bp_start,
  input logic             pause_start,
  input logic             bp_busy
);

  a_r2_start_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_start || pause_start) |-> (rx_level >= rx_thresh));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    bp_start |-> !jam_o);

  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_busy && bp_start) |-> 1'b0 || !bp_busy);

  a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req_o && !pause_ack && full_dup) |=> (pause_req_o || !full_dup));

  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req_o && pause_ack) |=> !pause_req_o);

  a_r12_flip_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (full_dup != $past(full_dup)) |-> (!jam_o && !pause_req_o));

  a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({jam_o, pause_req_o}));

  a_r13_jam_half: assert property (@(posedge clk) disable iff (!rst_n)
    jam_o |-> !full_dup);

endmodule

bind rx_throttle rx_throttle_chk #(.LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_level    (rx_level),
  .rx_thresh   (rx_thresh),
  .full_dup    (full_dup),
  .pause_ack   (pause_ack),
  .jam_o       (jam_o),
  .pause_req_o (pause_req_o),
  .bp_start    (bp_start_w),
  .pause_start (pause_start_w),
  .bp_busy     (bp_busy_w)
);

// File: tb/rx_throttle_test.sv
module rx_throttle_test;

  localparam int LVL_W   = 8;
  localparam int CLK_MHZ = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LVL_W-1:0] rx_level;
  logic [LVL_W-1:0] rx_thresh;
  logic             pre_ok;
  logic             addr_hit;
  logic             full_dup;
  logic             spd_100;
  logic [3:0]       dur_code;
  logic             any_frame;
  logic [2:0]       mode_en;
  logic             pause_ack;
  logic             jam_o;
  logic             pause_req_o;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  int run    = 0;
  int popped = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rx_throttle #(.LVL_W(LVL_W), .CLK_MHZ(CLK_MHZ)) uut (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_thresh(rx_thresh),
    .pre_ok(pre_ok), .addr_hit(addr_hit), .full_dup(full_dup),
    .spd_100(spd_100), .dur_code(dur_code), .any_frame(any_frame),
    .mode_en(mode_en), .pause_ack(pause_ack), .jam_o(jam_o),
    .pause_req_o(pause_req_o)
  );

  // expected cycles, derived from the microsecond table
  function automatic int exp_len(input int code, input bit fast);
    int us_x10;
    int tbl[5] = '{50, 100, 150, 250, 500};
    us_x10 = (code < 5) ? tbl[code] : 1000 + (code - 5) * 500;
    if (!fast) us_x10 += 22;
    return us_x10 * CLK_MHZ / 10;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: measure each jam run and compare against the scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (jam_o) run++;
      else if (run != 0) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected jam run", run, 0);
        else begin
          popped = exp_q.pop_front();
          chk(run == popped, "R7/R8/R9/R10/R12 jam length", run, popped);
        end
        run = 0;
      end
    end
  end

  task automatic pulse_pre();
    @(negedge clk) pre_ok = 1'b1;
    @(negedge clk) pre_ok = 1'b0;
  endtask

  task automatic pulse_addr();
    @(negedge clk) addr_hit = 1'b1;
    @(negedge clk) addr_hit = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic one_len(input int code, input bit fast);
    @(negedge clk);
    dur_code = 4'(code);
    spd_100  = fast;
    exp_q.push_back(exp_len(code, fast));
    pulse_pre();
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_level = 0; rx_thresh = 8; pre_ok = 0; addr_hit = 0;
    full_dup = 0; spd_100 = 1; dur_code = 0; any_frame = 0; mode_en = 0;
    pause_ack = 0;
    repeat (3) @(negedge clk);
    chk(!jam_o && !pause_req_o, "R1 reset outputs", {jam_o, pause_req_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!jam_o && !pause_req_o, "R1 after reset", {jam_o, pause_req_o}, 0);

    // half duplex, promiscuous mode, below threshold: nothing (R2)
    any_frame = 1; rx_level = 7;
    pulse_pre();
    repeat (3) @(negedge clk);
    chk(!jam_o, "R2 below threshold", jam_o, 0);

    // level reached, no preamble: nothing (R4)
    rx_level = 8;
    repeat (5) @(negedge clk);
    chk(!jam_o, "R4 no preamble", jam_o, 0);

    // R3/R4: preamble alone, no address, mode bits clear
    exp_q.push_back(exp_len(0, 1));
    pulse_pre();
    chk(jam_o, "R4 jam after preamble", jam_o, 1);
    drain();

    // R3: mode bits and address do not matter in promiscuous mode
    mode_en = 3'b111;
    exp_q.push_back(exp_len(0, 1));
    pulse_pre();
    drain();
    mode_en = 3'b000;

    // R7/R8 duration table extremes and middle
    one_len(0, 0);
    one_len(3, 1);
    one_len(4, 1);
    one_len(5, 0);
    one_len(15, 1);
    one_len(15, 0);

    // R9: code change during a running jam
    dur_code = 0; spd_100 = 1;
    exp_q.push_back(exp_len(0, 1));
    pulse_pre();
    dur_code = 4'hF; spd_100 = 0;
    drain();
    dur_code = 0; spd_100 = 1;

    // R10: retrigger mid-run dropped
    exp_q.push_back(exp_len(0, 1));
    pulse_pre();
    repeat (5) @(negedge clk);
    pulse_pre();
    drain();

    // R10: preamble held, second run only after expiry
    exp_q.push_back(exp_len(0, 1));
    exp_q.push_back(exp_len(0, 1));
    @(negedge clk) pre_ok = 1'b1;
    repeat (30) @(negedge clk);
    pre_ok = 1'b0;
    drain();

    // R6: address-qualified half duplex
    any_frame = 0; mode_en = 3'b000;
    pulse_addr();
    repeat (3) @(negedge clk);
    chk(!jam_o, "R6 common enable off", jam_o, 0);
    mode_en = 3'b001;
    pulse_addr();
    repeat (3) @(negedge clk);
    chk(!jam_o, "R6 bit2 clear", jam_o, 0);
    mode_en = 3'b101;
    pulse_pre();
    repeat (3) @(negedge clk);
    chk(!jam_o, "R6 preamble without address", jam_o, 0);
    exp_q.push_back(exp_len(0, 1));
    pulse_addr();
    chk(jam_o, "R6 address match starts jam", jam_o, 1);
    drain();

    // R12: duplex flip cuts a running jam
    any_frame = 1; rx_level = 7;
    rx_level = 8;
    exp_q.push_back(10);
    pulse_pre();
    repeat (9) @(negedge clk);
    rx_level = 7;
    full_dup = 1;
    #1 chk(!jam_o, "R12 jam dropped same cycle", jam_o, 0);
    drain();

    // R5: full duplex promiscuous, immediate request
    chk(!pause_req_o, "R2 no request below level", pause_req_o, 0);
    @(negedge clk) rx_level = 9;
    @(negedge clk);
    chk(pause_req_o, "R5 request after level", pause_req_o, 1);
    repeat (20) @(negedge clk);
    chk(pause_req_o, "R11 held until ack", pause_req_o, 1);
    pulse_pre();
    chk(!jam_o, "R13 no jam in full duplex", jam_o, 0);
    @(negedge clk) pause_ack = 1'b1;
    @(negedge clk) pause_ack = 1'b0;
    chk(!pause_req_o, "R11 released by ack", pause_req_o, 0);
    repeat (10) @(negedge clk);
    chk(!pause_req_o, "R11 no repeat without re-crossing", pause_req_o, 0);
    @(negedge clk) rx_level = 5;
    @(negedge clk) rx_level = 9;
    @(negedge clk);
    chk(pause_req_o, "R11 new request after re-crossing", pause_req_o, 1);
    @(negedge clk) pause_ack = 1'b1;
    @(negedge clk) pause_ack = 1'b0;

    // R6: address-qualified full duplex
    any_frame = 0; mode_en = 3'b010;
    @(negedge clk) rx_level = 5;
    @(negedge clk) rx_level = 9;
    repeat (3) @(negedge clk);
    chk(!pause_req_o, "R6 no strobe no request", pause_req_o, 0);
    pulse_addr();
    chk(!pause_req_o, "R6 bit2 clear blocks pause", pause_req_o, 0);
    mode_en = 3'b110;
    pulse_addr();
    chk(pause_req_o, "R6 address match raises pause", pause_req_o, 1);

    // R12: flip to half drops the request at once and discards it
    full_dup = 0;
    #1 chk(!pause_req_o, "R12 request dropped same cycle", pause_req_o, 0);
    any_frame = 1;
    repeat (5) @(negedge clk);
    chk(!pause_req_o && !jam_o, "R13 no request in half duplex",
        {jam_o, pause_req_o}, 0);
    full_dup = 1;
    repeat (4) @(negedge clk);
    chk(!pause_req_o, "R12 pending request discarded", pause_req_o, 0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule